// File: doc/BRIEF.md
# Segment Translation and Protection Unit

The unit takes a 16-bit segment selector, a 32-bit offset and the caller's privilege level. From these it produces a 32-bit linear address, or a fault code that says why the access was refused. On each request it fetches the 8-byte descriptor for the selected segment. The fetch goes through a 32-bit read port with a ready handshake. The unit then checks three things: the present bit, the privilege level and the segment limit. It reports the outcome with a one-cycle done strobe.

Selector bit 2 chooses between two descriptor tables. When it is clear the unit uses the global table, whose base is given on `gtab_base`. When it is set the unit uses the local table, whose base is given on `ltab_base`. Bits 15:3 of the selector form the entry number, which is 13 bits wide, so each table can hold up to 8192 entries. The address of an entry is the table base plus eight times the entry number. The first word at that address holds the segment base. The second word holds the attribute word:
- bit 31 is the present flag;
- bits 30:29 are the segment privilege level;
- bits 19:0 are the limit, counted in bytes.

Top module: `seg_xlate`

## Requirements
- R1: After reset, and before any request, `done`, `rd_en` and `fault` are all 0.
- R2: For a request, the first read goes to (table base + 8 × selector[15:3]) and the second read goes to that address + 4. The table base is `ltab_base` when selector bit 2 is 1 and `gtab_base` when it is 0. The two reads are issued one after the other.
- R3: When no fault occurs, `lin_addr` equals the first word (the base) plus the offset, modulo 2^32, and `fault` is 0 (code NONE).
- R4: An offset greater than attribute bits 19:0 gives fault code 3 (LIMIT), and `lin_addr` is then 0. An offset equal to the limit is accepted.
- R5: A privilege level greater than attribute bits 30:29 gives fault code 2 (PRIV). An equal privilege level is accepted.
- R6: When attribute bit 31 is 0, the result is fault code 1 (ABSENT), even if the privilege check or the limit check would also fail.
- R7: When both the privilege check and the limit check fail, the result is code 2 (PRIV).
- R8: `done` is high for exactly one cycle per request. It follows the cycle in which the second word was accepted. While `rd_ready` is low, `rd_en` and `rd_addr` hold their values.
- R9: A request that arrives while a translation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Start a translation (sampled only when idle) |
| sel | input | 16 | Segment selector |
| offset | input | 32 | Offset within the segment |
| cpl | input | 2 | Caller's privilege level |
| gtab_base | input | 32 | Global table base (held stable during a request) |
| ltab_base | input | 32 | Local table base (held stable during a request) |
| rd_en | output | 1 | Descriptor read request |
| rd_addr | output | 32 | Descriptor word address |
| rd_data | input | 32 | Read data, valid when rd_ready is high |
| rd_ready | input | 1 | Read accepted and data valid |
| done | output | 1 | Result valid for one cycle |
| lin_addr | output | 32 | Linear address (0 on a fault) |
| fault | output | 2 | 0 NONE, 1 ABSENT, 2 PRIV, 3 LIMIT |

## Verification
The hardest cases to reach are those where several checks fail at once. In these cases the fault ordering alone decides the code that is reported. The bench fills the memory model with descriptors that fail on purpose in two or three ways together, for example an absent segment that also has a high privilege level and a small limit. The bench also holds `rd_ready` low for several cycles. This keeps the unit busy while a second request arrives, which tests that the second request is ignored.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int AW      = 32,
  parameter int LIMIT_W = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [15:0]   sel,
  input  logic [AW-1:0] offset,
  input  logic [1:0]    cpl,
  input  logic [AW-1:0] gtab_base,
  input  logic [AW-1:0] ltab_base,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  input  logic [31:0]   rd_data,
  input  logic          rd_ready,
  output logic          done,
  output logic [AW-1:0] lin_addr,
  output logic [1:0]    fault
);
  localparam logic [1:0] F_NONE = 2'd0, F_ABSENT = 2'd1, F_PRIV = 2'd2, F_LIMIT = 2'd3;

  typedef enum logic [1:0] {IDLE, RD_BASE, RD_ATTR, FIN} st_t;
  st_t st;

  logic [15:0]   sel_q;
  logic [AW-1:0] off_q;
  logic [1:0]    cpl_q;
  logic [AW-1:0] base_q;
  logic [31:0]   attr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      sel_q  <= '0;
      off_q  <= '0;
      cpl_q  <= '0;
      base_q <= '0;
      attr_q <= '0;
    end else begin
      case (st)
        IDLE: if (req) begin
          sel_q <= sel;
          off_q <= offset;
          cpl_q <= cpl;
          st    <= RD_BASE;
        end
        RD_BASE: if (rd_ready) begin
          base_q <= AW'(rd_data);
          st     <= RD_ATTR;
        end
        RD_ATTR: if (rd_ready) begin
          attr_q <= rd_data;
          st     <= FIN;
        end
        default: st <= IDLE;
      endcase
    end
  end

  wire [AW-1:0] tab_base  = sel_q[2] ? ltab_base : gtab_base;
  wire [AW-1:0] desc_addr = tab_base + AW'({sel_q[15:3], 3'b000});

  assign rd_en   = (st == RD_BASE) || (st == RD_ATTR);
  assign rd_addr = desc_addr + ((st == RD_ATTR) ? AW'(4) : AW'(0));

  wire          present = attr_q[31];
  wire [1:0]    dpl     = attr_q[30:29];
  wire [AW-1:0] limit   = AW'(attr_q[LIMIT_W-1:0]);

  logic [1:0] code;
  always_comb begin
    if (!present)           code = F_ABSENT;
    else if (cpl_q > dpl)   code = F_PRIV;
    else if (off_q > limit) code = F_LIMIT;
    else                    code = F_NONE;
  end

  assign done     = (st == FIN);
  assign fault    = done ? code : F_NONE;
  assign lin_addr = (done && code == F_NONE) ? base_q + off_q : '0;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ready,
  input logic          done,
  input logic [AW-1:0] lin_addr,
  input logic [1:0]    fault
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_en);
  // R8
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  done_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_ready));
  // R8
  hold_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_ready) |=> (rd_en && $stable(rd_addr)));
  // R2
  aligned_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr[1:0] == 2'b00));
  // R4
  no_addr_on_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'd0) |-> (lin_addr == '0));
endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
  .rd_ready(rd_ready), .done(done), .lin_addr(lin_addr), .fault(fault)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0;
  logic [15:0] sel = '0;
  logic [31:0] offset = '0;
  logic [1:0]  cpl = '0;
  logic [31:0] gtab_base = 32'h0000_0000;
  logic [31:0] ltab_base = 32'h0000_0080;
  logic        rd_en, rd_ready, done;
  logic [31:0] rd_addr, rd_data, lin_addr;
  logic [1:0]  fault;

  int checks = 0, fails = 0;
  int waits = 0;
  int wcnt = 0;
  int nlog = 0;
  logic [31:0] log0, log1;
  logic [31:0] mem [64];

  always #4 clk = ~clk;

  seg_xlate i_seg_xlate (
    .clk(clk), .rst_n(rst_n), .req(req), .sel(sel), .offset(offset), .cpl(cpl),
    .gtab_base(gtab_base), .ltab_base(ltab_base), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_ready(rd_ready), .done(done), .lin_addr(lin_addr), .fault(fault)
  );

  assign rd_data  = mem[rd_addr[7:2]];
  assign rd_ready = rd_en && (wcnt == waits);

  always @(posedge clk) begin
    if (rd_en) wcnt <= rd_ready ? 0 : wcnt + 1;
    else       wcnt <= 0;
    if (rd_en && rd_ready) begin
      if (nlog == 0) log0 <= rd_addr;
      if (nlog == 1) log1 <= rd_addr;
      nlog <= nlog + 1;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] tbase, input int idx, input logic [31:0] base,
                          input logic p, input logic [1:0] dpl, input logic [19:0] lim);
    int w = int'(tbase[7:2]) + idx * 2;
    mem[w]     = base;
    mem[w + 1] = {p, dpl, 9'd0, lim};
  endtask

  task automatic xlate(input string r, input logic [15:0] s, input logic [31:0] off,
                       input logic [1:0] c, input logic [1:0] ef, input logic [31:0] ea,
                       input logic [31:0] eaddr0);
    bit seen = 0;
    @(negedge clk);
    nlog = 0;
    sel = s; offset = off; cpl = c; req = 1;
    @(negedge clk);
    req = 0;
    for (int i = 0; i < 100; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk({r, " done seen"}, 32'(seen), 32'd1);
    chk({r, " fault"}, 32'(fault), 32'(ef));
    chk({r, " lin_addr"}, lin_addr, ea);
    chk("R2 first read addr", log0, eaddr0);
    chk("R2 second read addr", log1, eaddr0 + 4);
    chk("R2 read count", 32'(nlog), 32'd2);
    @(negedge clk);
    chk("R8 done single cycle", 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 done at reset", 32'(done), 32'd0);
    chk("R1 rd_en at reset", 32'(rd_en), 32'd0);
    chk("R1 fault at reset", 32'(fault), 32'd0);
  endtask

  task automatic t_basic;
    xlate("R3 global basic", 16'h0008, 32'h0000_1234, 2'd0, 2'd0, 32'h1000_1234, 32'h08);
  endtask

  task automatic t_local_wrap;
    xlate("R3 local wrap R5 equal", 16'h0014, 32'h0000_0200, 2'd2, 2'd0, 32'h0000_0100, 32'h90);
  endtask

  task automatic t_limit;
    xlate("R4 offset equals limit", 16'h0010, 32'h0000_0FFF, 2'd1, 2'd0, 32'h2000_0FFF, 32'h10);
    xlate("R4 offset over limit", 16'h0010, 32'h0000_1000, 2'd1, 2'd3, 32'h0, 32'h10);
  endtask

  task automatic t_priv;
    xlate("R5 cpl above dpl", 16'h0018, 32'h0000_0004, 2'd3, 2'd2, 32'h0, 32'h18);
  endtask

  task automatic t_absent;
    xlate("R6 absent beats all", 16'h0020, 32'h0000_9999, 2'd3, 2'd1, 32'h0, 32'h20);
  endtask

  task automatic t_order;
    xlate("R7 priv before limit", 16'h0028, 32'h0000_0100, 2'd1, 2'd2, 32'h0, 32'h28);
  endtask

  task automatic t_waits;
    waits = 3;
    xlate("R8 with wait states", 16'h0008, 32'h0000_0010, 2'd0, 2'd0, 32'h1000_0010, 32'h08);
    waits = 0;
  endtask

  task automatic t_busy;
    bit seen = 0;
    waits = 2;
    @(negedge clk);
    nlog = 0;
    sel = 16'h0008; offset = 32'h0000_0040; cpl = 2'd0; req = 1;
    @(negedge clk);
    sel = 16'h0018; offset = 32'h0000_0001; cpl = 2'd3;
    @(negedge clk);
    req = 0;
    for (int i = 0; i < 100; i++) begin
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R9 done seen", 32'(seen), 32'd1);
    chk("R9 busy request ignored fault", 32'(fault), 32'd0);
    chk("R9 busy request ignored lin", lin_addr, 32'h1000_0040);
    chk("R9 first read addr", log0, 32'h08);
    @(negedge clk);
    @(negedge clk);
    chk("R9 no second translation", 32'(rd_en || done), 32'd0);
    waits = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    put_desc(32'h00, 1, 32'h1000_0000, 1'b1, 2'd3, 20'hFFFFF);
    put_desc(32'h00, 2, 32'h2000_0000, 1'b1, 2'd1, 20'h00FFF);
    put_desc(32'h00, 3, 32'h3000_0000, 1'b1, 2'd2, 20'hFFFFF);
    put_desc(32'h00, 4, 32'h4000_0000, 1'b0, 2'd0, 20'h00010);
    put_desc(32'h00, 5, 32'h5000_0000, 1'b1, 2'd0, 20'h00010);
    put_desc(32'h80, 2, 32'hFFFF_FF00, 1'b1, 2'd2, 20'hFFFFF);
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_local_wrap();
    t_limit();
    t_priv();
    t_absent();
    t_order();
    t_waits();
    t_busy();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog expired: actual hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule